// File: doc/BRIEF.md
# Complex Carrier Mixer with Rounding and Gain

This block multiplies a pair of 12-bit signed samples by sine and cosine values from an external oscillator. The pair is an even-time I sample and an odd-time Q sample. From these it builds four individual products and two complex sums. Before the multipliers, a programmable offset is added to each sample. Each product is cut from its full width back to 12 bits. The control line `rnd_en` selects whether the cut truncates toward minus infinity or rounds half to even.

Two cross products are combined into the I and Q symbol values:

- I = even I product + odd Q product
- Q = even Q product + odd I product

The sums saturate to 12 bits. An optional stage then doubles them, also with saturation. A second pair of programmable offsets is added at the symbol outputs.

A clear control removes the odd-time terms from the sums, so the symbol path carries the even-time products alone. This is how the even outputs of a high-rate mode are forwarded. In complex mode the oscillator supplies an odd pair equal to (cosine, minus sine) of the even pair. In high-rate mode the two pairs belong to successive sample times.

All four products and both symbol values leave the block together, four clock cycles after the input. A valid strobe travels with them.

Top module: `cplx_mixer`

## Requirements
- R1: `out_vld` equals `in_vld` delayed by exactly four rising clock edges. While `rst_n` is low, every output is zero.
- R2: Before multiplication, `ofs_in_i` is added to `smp_i` and `ofs_in_q` is added to `smp_q`. The result saturates to the range -2048..2047.
- R3: The products are formed from the offset samples (xi, xq) as follows: `prod_i_ev` = xi·`cos_e`, `prod_q_ev` = xi·`sin_e`, `prod_i_od` = xq·`cos_o`, `prod_q_od` = xq·`sin_o`. All operands are two's complement.
- R4: With `rnd_en` = 0, each full product is shifted right arithmetically by 11 bits (floor division by 2048).
- R5: With `rnd_en` = 1, the 11 dropped bits are rounded. Above one half, the kept value rounds up. Below one half, it rounds down. At exactly one half, it rounds up only when the kept value is odd.
- R6: A reduced product beyond 2047 (only -2048 times -2048) saturates to 2047. A product output never shows -2048.
- R7: The I sum is `prod_i_ev` + `prod_q_od` and the Q sum is `prod_q_ev` + `prod_i_od`. Each saturates to -2048..2047.
- R8: With `dbl_en` = 1, each sum is doubled and saturates to -2048..2047. With `dbl_en` = 0, the sum passes unchanged.
- R9: With `sum_clr` = 1, the odd-time products are left out of the sums, so the doubling stage sees `prod_i_ev` and `prod_q_ev`. The product outputs are not affected by `sum_clr`, `dbl_en` or the output offsets.
- R10: `sym_i` and `sym_q` are the doubling-stage results plus `ofs_out_i` and `ofs_out_q`, saturated to -2048..2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample pair is valid |
| smp_i | input | 12 | Even-time I sample, signed |
| smp_q | input | 12 | Odd-time Q sample, signed |
| cos_e | input | 12 | Even-time cosine, signed |
| sin_e | input | 12 | Even-time sine, signed |
| cos_o | input | 12 | Odd-time cosine, signed |
| sin_o | input | 12 | Odd-time sine, signed |
| ofs_in_i | input | 12 | Offset added to the I sample, signed |
| ofs_in_q | input | 12 | Offset added to the Q sample, signed |
| ofs_out_i | input | 12 | Offset added to the I symbol, signed |
| ofs_out_q | input | 12 | Offset added to the Q symbol, signed |
| rnd_en | input | 1 | 1: round half to even, 0: truncate |
| dbl_en | input | 1 | 1: double the sums with saturation |
| sum_clr | input | 1 | 1: leave the odd products out of the sums |
| out_vld | output | 1 | Outputs are valid |
| prod_i_ev | output | 12 | Sample I times even cosine |
| prod_q_ev | output | 12 | Sample I times even sine |
| prod_i_od | output | 12 | Sample Q times odd cosine |
| prod_q_od | output | 12 | Sample Q times odd sine |
| sym_i | output | 12 | I symbol value |
| sym_q | output | 12 | Q symbol value |

## Verification
Every control travels in the pipeline beside its data. A stage that held a stale control bit therefore shows up as a wrong value on the very output word carrying that sample, four cycles after the input. It does not show up as a drift over later samples.

A misplaced rounding tie or a wrapped instead of saturated addition only appears for certain operand values. For that reason, exact half fractions and full-scale operands are driven directly, and random vectors are weighted toward extreme values. A valid strobe that slips out of step with the data is caught on the first valid word that follows a gap in `in_vld`.

// File: rtl/cmix_pkg.sv
`timescale 1ns/1ps
package cmix_pkg;
    // Per-sample controls, carried beside the data through the pipeline
    typedef struct packed {
        logic rnd;
        logic dbl;
        logic clr;
    } cmix_ctl_t;
endpackage

// File: rtl/cmix_sat_add.sv
`timescale 1ns/1ps
// Two's complement addition clamped to the W-bit range
module cmix_sat_add #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W:0] s;
    logic       ovf;

    always_comb begin
        s   = {a[W-1], a} + {b[W-1], b};
        ovf = s[W] ^ s[W-1];
        if (ovf) y = s[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else     y = s[W-1:0];
    end
endmodule

// File: rtl/cmix_dbl_sat.sv
`timescale 1ns/1ps
// Optional multiply by two with saturation to full scale
module cmix_dbl_sat #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    input  logic         en,
    output logic [W-1:0] y
);
    logic ovf;

    always_comb begin
        ovf = a[W-1] ^ a[W-2];
        if (!en)     y = a;
        else if (ovf) y = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else          y = {a[W-2:0], 1'b0};
    end
endmodule

// File: rtl/cmix_prod_rnd.sv
`timescale 1ns/1ps
// Signed multiply, drop CW-1 fraction bits by floor or round-half-even,
// then clamp to DW bits
module cmix_prod_rnd #(
    parameter int DW = 12,
    parameter int CW = 12
) (
    input  logic [DW-1:0] a,
    input  logic [CW-1:0] b,
    input  logic          rnd,
    output logic [DW-1:0] y
);
    localparam int PW = DW + CW;
    localparam int SH = CW - 1;
    localparam int KW = PW - SH;

    logic [PW-1:0] p;
    logic [KW-1:0] kept;
    logic          rup;
    logic [KW:0]   r;
    logic [KW:DW-1] top;

    always_comb begin
        p    = {{CW{a[DW-1]}}, a} * {{DW{b[CW-1]}}, b};
        kept = p[PW-1:SH];
        // above half, or exactly half with an odd kept value
        rup  = rnd & p[SH-1] & ((|p[SH-2:0]) | p[SH]);
        r    = {kept[KW-1], kept} + {{KW{1'b0}}, rup};
        top  = r[KW:DW-1];
        if ((&top) || !(|top)) y = r[DW-1:0];
        else if (r[KW])        y = {1'b1, {(DW-1){1'b0}}};
        else                   y = {1'b0, {(DW-1){1'b1}}};
    end
endmodule

// File: rtl/cplx_mixer.sv
`timescale 1ns/1ps
module cplx_mixer
    import cmix_pkg::*;
#(
    parameter int DW = 12,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] smp_i,
    input  logic [DW-1:0] smp_q,
    input  logic [CW-1:0] cos_e,
    input  logic [CW-1:0] sin_e,
    input  logic [CW-1:0] cos_o,
    input  logic [CW-1:0] sin_o,
    input  logic [DW-1:0] ofs_in_i,
    input  logic [DW-1:0] ofs_in_q,
    input  logic [DW-1:0] ofs_out_i,
    input  logic [DW-1:0] ofs_out_q,
    input  logic          rnd_en,
    input  logic          dbl_en,
    input  logic          sum_clr,
    output logic          out_vld,
    output logic [DW-1:0] prod_i_ev,
    output logic [DW-1:0] prod_q_ev,
    output logic [DW-1:0] prod_i_od,
    output logic [DW-1:0] prod_q_od,
    output logic [DW-1:0] sym_i,
    output logic [DW-1:0] sym_q
);
    localparam int NPROD = 4;

    // stage 1: offset samples and registered coefficients
    typedef struct packed {
        logic          vld;
        cmix_ctl_t     ctl;
        logic [DW-1:0] xi, xq;
        logic [CW-1:0] ce, se, co, so;
        logic [DW-1:0] ooi, ooq;
    } st1_t;

    // stage 2: reduced products
    typedef struct packed {
        logic                     vld;
        cmix_ctl_t                ctl;
        logic [NPROD-1:0][DW-1:0] pr;
        logic [DW-1:0]            ooi, ooq;
    } st2_t;

    // stage 3: sums after doubling
    typedef struct packed {
        logic                     vld;
        logic [NPROD-1:0][DW-1:0] pr;
        logic [DW-1:0]            si, sq;
        logic [DW-1:0]            ooi, ooq;
    } st3_t;

    // stage 4: outputs
    typedef struct packed {
        logic                     vld;
        logic [NPROD-1:0][DW-1:0] pr;
        logic [DW-1:0]            si, sq;
    } st4_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
        st4_t s4;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    // input offsets
    logic [DW-1:0] xi_ofs, xq_ofs;

    cmix_sat_add #(.W(DW)) u_ofs_in_i (.a(smp_i), .b(ofs_in_i), .y(xi_ofs));
    cmix_sat_add #(.W(DW)) u_ofs_in_q (.a(smp_q), .b(ofs_in_q), .y(xq_ofs));

    // product index: 0 = I even, 1 = Q even, 2 = I odd, 3 = Q odd
    logic [NPROD-1:0][DW-1:0] mul_x;
    logic [NPROD-1:0][CW-1:0] mul_c;
    logic [NPROD-1:0][DW-1:0] mul_p;

    assign mul_x = {pipe_q.s1.xq, pipe_q.s1.xq, pipe_q.s1.xi, pipe_q.s1.xi};
    assign mul_c = {pipe_q.s1.so, pipe_q.s1.co, pipe_q.s1.se, pipe_q.s1.ce};

    for (genvar g = 0; g < NPROD; g++) begin : g_mul
        cmix_prod_rnd #(.DW(DW), .CW(CW)) u_mul (
            .a   (mul_x[g]),
            .b   (mul_c[g]),
            .rnd (pipe_q.s1.ctl.rnd),
            .y   (mul_p[g])
        );
    end

    // cross sums with optional odd-term clear, then doubling
    logic [DW-1:0] odd_i, odd_q, sum_i, sum_q, dbl_i, dbl_q;

    assign odd_i = pipe_q.s2.ctl.clr ? '0 : pipe_q.s2.pr[3];
    assign odd_q = pipe_q.s2.ctl.clr ? '0 : pipe_q.s2.pr[2];

    cmix_sat_add #(.W(DW)) u_sum_i (.a(pipe_q.s2.pr[0]), .b(odd_i), .y(sum_i));
    cmix_sat_add #(.W(DW)) u_sum_q (.a(pipe_q.s2.pr[1]), .b(odd_q), .y(sum_q));

    cmix_dbl_sat #(.W(DW)) u_dbl_i (.a(sum_i), .en(pipe_q.s2.ctl.dbl), .y(dbl_i));
    cmix_dbl_sat #(.W(DW)) u_dbl_q (.a(sum_q), .en(pipe_q.s2.ctl.dbl), .y(dbl_q));

    // output offsets
    logic [DW-1:0] so_i, so_q;

    cmix_sat_add #(.W(DW)) u_ofs_out_i (.a(pipe_q.s3.si), .b(pipe_q.s3.ooi), .y(so_i));
    cmix_sat_add #(.W(DW)) u_ofs_out_q (.a(pipe_q.s3.sq), .b(pipe_q.s3.ooq), .y(so_q));

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.s1.vld     = in_vld;
        pipe_d.s1.ctl.rnd = rnd_en;
        pipe_d.s1.ctl.dbl = dbl_en;
        pipe_d.s1.ctl.clr = sum_clr;
        pipe_d.s1.xi      = xi_ofs;
        pipe_d.s1.xq      = xq_ofs;
        pipe_d.s1.ce      = cos_e;
        pipe_d.s1.se      = sin_e;
        pipe_d.s1.co      = cos_o;
        pipe_d.s1.so      = sin_o;
        pipe_d.s1.ooi     = ofs_out_i;
        pipe_d.s1.ooq     = ofs_out_q;

        pipe_d.s2.vld = pipe_q.s1.vld;
        pipe_d.s2.ctl = pipe_q.s1.ctl;
        pipe_d.s2.pr  = mul_p;
        pipe_d.s2.ooi = pipe_q.s1.ooi;
        pipe_d.s2.ooq = pipe_q.s1.ooq;

        pipe_d.s3.vld = pipe_q.s2.vld;
        pipe_d.s3.pr  = pipe_q.s2.pr;
        pipe_d.s3.si  = dbl_i;
        pipe_d.s3.sq  = dbl_q;
        pipe_d.s3.ooi = pipe_q.s2.ooi;
        pipe_d.s3.ooq = pipe_q.s2.ooq;

        pipe_d.s4.vld = pipe_q.s3.vld;
        pipe_d.s4.pr  = pipe_q.s3.pr;
        pipe_d.s4.si  = so_i;
        pipe_d.s4.sq  = so_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_vld   = pipe_q.s4.vld;
    assign prod_i_ev = pipe_q.s4.pr[0];
    assign prod_q_ev = pipe_q.s4.pr[1];
    assign prod_i_od = pipe_q.s4.pr[2];
    assign prod_q_od = pipe_q.s4.pr[3];
    assign sym_i     = pipe_q.s4.si;
    assign sym_q     = pipe_q.s4.sq;
endmodule

// File: rtl/cmix_chk.sv
`timescale 1ns/1ps
module cmix_chk #(
    parameter int DW = 12,
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_vld,
    input logic [CW-1:0] cos_e,
    input logic [DW-1:0] ofs_out_i,
    input logic          dbl_en,
    input logic          sum_clr,
    input logic          out_vld,
    input logic [DW-1:0] prod_i_ev,
    input logic [DW-1:0] sym_i
);
    localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    // cycles since reset release, saturating
    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    logic warm;
    assign warm = (since_rst >= 3'd4);

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_vld == $past(in_vld, 4))); // R1

    AST_NO_EARLY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !warm |-> !out_vld); // R1

    AST_ZERO_COEF: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_vld && $past(cos_e, 4) == '0) |-> (prod_i_ev == '0)); // R3

    AST_PROD_NO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (prod_i_ev != MINV)); // R6

    AST_DBL_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_vld && $past(dbl_en, 4) && $past(ofs_out_i, 4) == '0)
        |-> (!sym_i[0] || sym_i == MAXV)); // R8

    AST_CLR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_vld && $past(sum_clr, 4) && !$past(dbl_en, 4)
         && $past(ofs_out_i, 4) == '0) |-> (sym_i == prod_i_ev)); // R9
endmodule

bind cplx_mixer cmix_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .cos_e     (cos_e),
    .ofs_out_i (ofs_out_i),
    .dbl_en    (dbl_en),
    .sum_clr   (sum_clr),
    .out_vld   (out_vld),
    .prod_i_ev (prod_i_ev),
    .sym_i     (sym_i)
);

// File: tb/sim_cplx_mixer.sv
`timescale 1ns/1ps
module sim_cplx_mixer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [11:0] smp_i = '0, smp_q = '0;
    logic [11:0] cos_e = '0, sin_e = '0, cos_o = '0, sin_o = '0;
    logic [11:0] ofs_in_i = '0, ofs_in_q = '0, ofs_out_i = '0, ofs_out_q = '0;
    logic        rnd_en = 1'b0, dbl_en = 1'b0, sum_clr = 1'b0;
    logic        out_vld;
    logic [11:0] prod_i_ev, prod_q_ev, prod_i_od, prod_q_od, sym_i, sym_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cplx_mixer u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .smp_i(smp_i), .smp_q(smp_q),
        .cos_e(cos_e), .sin_e(sin_e), .cos_o(cos_o), .sin_o(sin_o),
        .ofs_in_i(ofs_in_i), .ofs_in_q(ofs_in_q),
        .ofs_out_i(ofs_out_i), .ofs_out_q(ofs_out_q),
        .rnd_en(rnd_en), .dbl_en(dbl_en), .sum_clr(sum_clr),
        .out_vld(out_vld),
        .prod_i_ev(prod_i_ev), .prod_q_ev(prod_q_ev),
        .prod_i_od(prod_i_od), .prod_q_od(prod_q_od),
        .sym_i(sym_i), .sym_q(sym_q)
    );

    typedef struct {
        bit    vld;
        int    p0, p1, p2, p3, si, sq;
        string tag;
    } exp_t;

    exp_t pipe [4];

    function automatic int sat12(int v);
        if (v > 2047)  return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int reduce(int a, int b, bit rnd);
        int p, k, f;
        p = a * b;
        k = p >>> 11;
        f = p - k * 2048;
        if (rnd && (f > 1024 || (f == 1024 && (k % 2) != 0))) k = k + 1;
        return sat12(k);
    endfunction

    function automatic int s12(logic [11:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit v, int xi, int xq, int ce, int se, int co, int so,
                        int oii, int oiq, int ooi, int ooq,
                        bit r, bit d, bit c, string tag);
        exp_t e;
        int   ai, aq, si, sq;
        @(negedge clk);
        chk("R1", "out_vld", int'(out_vld), int'(pipe[3].vld));
        if (pipe[3].vld) begin
            chk(pipe[3].tag, "prod_i_ev", s12(prod_i_ev), pipe[3].p0);
            chk(pipe[3].tag, "prod_q_ev", s12(prod_q_ev), pipe[3].p1);
            chk(pipe[3].tag, "prod_i_od", s12(prod_i_od), pipe[3].p2);
            chk(pipe[3].tag, "prod_q_od", s12(prod_q_od), pipe[3].p3);
            chk(pipe[3].tag, "sym_i", s12(sym_i), pipe[3].si);
            chk(pipe[3].tag, "sym_q", s12(sym_q), pipe[3].sq);
        end
        for (int i = 3; i > 0; i--) pipe[i] = pipe[i-1];
        ai = sat12(xi + oii);
        aq = sat12(xq + oiq);
        e.vld = v;
        e.tag = tag;
        e.p0  = reduce(ai, ce, r);
        e.p1  = reduce(ai, se, r);
        e.p2  = reduce(aq, co, r);
        e.p3  = reduce(aq, so, r);
        si = sat12(e.p0 + (c ? 0 : e.p3));
        sq = sat12(e.p1 + (c ? 0 : e.p2));
        if (d) begin
            si = sat12(2 * si);
            sq = sat12(2 * sq);
        end
        e.si = sat12(si + ooi);
        e.sq = sat12(sq + ooq);
        pipe[0] = e;
        in_vld = v;
        smp_i = 12'(xi); smp_q = 12'(xq);
        cos_e = 12'(ce); sin_e = 12'(se); cos_o = 12'(co); sin_o = 12'(so);
        ofs_in_i = 12'(oii); ofs_in_q = 12'(oiq);
        ofs_out_i = 12'(ooi); ofs_out_q = 12'(ooq);
        rnd_en = r; dbl_en = d; sum_clr = c;
    endtask

    function automatic int pick();
        case ($urandom % 8)
            0: return -2048;
            1: return 2047;
            2: return 0;
            3: return 1024;
            4: return -1024;
            default: return int'($urandom % 4096) - 2048;
        endcase
    endfunction

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_c0de);
        for (int i = 0; i < 4; i++) begin
            pipe[i].vld = 1'b0;
            pipe[i].tag = "R1";
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset out_vld", int'(out_vld), 0);
        chk("R1", "reset sym_i", s12(sym_i), 0);
        chk("R1", "reset prod_q_od", s12(prod_q_od), 0);
        rst_n = 1'b1;

        // R3 pairing of samples and coefficients
        step(1, 100, -50, 2047, 1024, -1024, 512, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, -700, 900, -2048, 333, 77, -1500, 0, 0, 0, 0, 1, 0, 0, "R3");
        // R4 truncation is floor
        step(1, -1, 3, 1, 1024, 1024, -1024, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, -3, 5, 1024, 1023, -1025, 1024, 0, 0, 0, 0, 0, 0, 0, "R4");
        // R5 round half to even, including ties
        step(1, 1, 3, 1024, 1024, 1024, -1024, 0, 0, 0, 0, 1, 0, 0, "R5");
        step(1, -1, -3, 1024, 1024, 1024, 1024, 0, 0, 0, 0, 1, 0, 0, "R5");
        step(1, 5, 7, 1023, 1025, -1023, -1025, 0, 0, 0, 0, 1, 0, 0, "R5");
        // R6 product clamp
        step(1, -2048, -2048, -2048, 2047, -2048, -2048, 0, 0, 0, 0, 0, 0, 0, "R6");
        step(1, -2048, -2048, -2048, 2047, -2048, -2048, 0, 0, 0, 0, 1, 0, 0, "R6");
        // R2 input offset saturation
        step(1, 2000, -2000, 2047, 2047, 2047, 2047, 500, -500, 0, 0, 0, 0, 0, "R2");
        step(1, -10, 10, 2047, 1024, 2047, 1024, -5, 5, 0, 0, 1, 0, 0, "R2");
        // R7 sum saturation
        step(1, 2047, 2047, 2047, -2048, 2047, 2047, 0, 0, 0, 0, 0, 0, 0, "R7");
        step(1, -2048, 2047, 2047, 2047, 2047, -2048, 0, 0, 0, 0, 1, 0, 0, "R7");
        // R8 doubling, with and without overflow
        step(1, 400, 300, 2047, 1024, 1024, 2047, 0, 0, 0, 0, 0, 1, 0, "R8");
        step(1, 1500, -1500, 2047, 2047, 2047, -2047, 0, 0, 0, 0, 0, 1, 0, "R8");
        // R9 odd products left out, product outputs unchanged
        step(1, 900, 1200, 1500, -700, 2047, 2047, 0, 0, 0, 0, 0, 0, 1, "R9");
        step(1, 1800, -900, 2047, -2048, 800, 800, 0, 0, 300, 0, 1, 1, 1, "R9");
        // R10 output offset saturation
        step(1, 2047, 2047, 2047, 2047, 2047, 2047, 0, 0, 2047, -2048, 0, 0, 0, "R10");
        step(1, 100, 100, 100, 100, 100, 100, 0, 0, -7, 9, 0, 0, 0, "R10");
        // R1 valid gaps
        step(0, 5, 5, 5, 5, 5, 5, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 6, 6, 2047, 2047, 2047, 2047, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 7, 7, 5, 5, 5, 5, 0, 0, 0, 0, 0, 0, 0, "R1");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            bit v, r, d, c;
            v = ($urandom % 5) != 0;
            r = $urandom % 2;
            d = $urandom % 2;
            c = ($urandom % 4) == 0;
            step(v, pick(), pick(), pick(), pick(), pick(), pick(),
                 (($urandom % 3) == 0) ? pick() : 0,
                 (($urandom % 3) == 0) ? pick() : 0,
                 (($urandom % 3) == 0) ? pick() : 0,
                 (($urandom % 3) == 0) ? pick() : 0,
                 r, d, c, c ? "R9" : (d ? "R8" : "R7"));
        end
        for (int n = 0; n < 5; n++)
            step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule